// File: doc/BRIEF.md
# Round-Robin Way Allocator

The allocator decides which way of a set-associative array takes a newly arriving line. For a presented set number and that set's per-way valid bits, it names one way and says whether that choice displaces a live line. A free way is always taken in preference to displacing anything. When the set is full, the victim comes from a rotating pointer kept for that set alone.

The choice is purely combinational from the current inputs. The surrounding controller asserts a commit strobe in the cycle it acts on the choice. A committed displacement moves that set's pointer one step on at the next clock edge. Fills, lookups and uncommitted cycles leave every pointer unchanged.

Set count and associativity are parameters. A one-way array (direct mapped) and a one-set array (fully associative) are both legal configurations.

Top module: `way_alloc_rr`

## Requirements
- R1: Ways are numbered 0 to NUM_WAYS-1 (bit i of `way_valid_i` is way i). If any way is invalid, `way_sel_o` is the lowest-numbered invalid way and `evict_o` is 0, in the same cycle.
- R2: If all ways of the presented set are valid, `evict_o` is 1 and `way_sel_o` equals that set's rotating pointer, in the same cycle.
- R3: A clock edge with `commit_i` high and `evict_o` high advances the presented set's pointer by exactly one.
- R4: A pointer at NUM_WAYS-1 advances to 0.
- R5: A committed fill (`commit_i` high while `evict_o` is 0) leaves the pointer unchanged.
- R6: With `commit_i` low, no pointer changes, however long a full set is presented.
- R7: Every set has its own pointer; a displacement in one set leaves the pointers of all other sets unchanged.
- R8: Reset (`rst_n` low, asynchronous) sets every pointer to 0.
- R9: With NUM_WAYS = 1, `way_sel_o` is always 0 and `evict_o` equals the single valid bit, before and after committed displacements.
- R10: With NUM_SETS = 1, the single pointer rotates through all NUM_WAYS ways in order and wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_idx_i | input | SET_W | Set being allocated into |
| way_valid_i | input | NUM_WAYS | Valid bit of each way of that set |
| commit_i | input | 1 | The controller acts on this cycle's choice |
| way_sel_o | output | WAY_W | Chosen way number |
| evict_o | output | 1 | Chosen way currently holds a valid line |

## Verification
Partially filled sets are presented with holes at every position, including holes only above valid ways, which separates a lowest-free search from any other free-way choice. Full sets are committed repeatedly to walk a pointer through its wrap, and interleaving sets shows the pointers are separate. Committed fills, uncommitted full lookups and a mid-run reset each tell apart a pointer that moves only on committed displacements from one that moves on other events. Direct-mapped and single-set instances cover both degenerate shapes.

// File: rtl/wa_pkg.sv
package wa_pkg;

    // Outcome of one allocation decision.
    typedef enum logic {
        ALLOC_FILL  = 1'b0,
        ALLOC_EVICT = 1'b1
    } alloc_kind_e;

    // Width of an index that addresses n items, never below one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wa_free_finder.sv
module wa_free_finder #(
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0] valid_i,
    output logic                any_free_o,
    output logic [WAY_W-1:0]    free_idx_o
);

    // all_below[i] is set when every way under i is valid.
    logic [NUM_WAYS:0]   all_below;
    logic [NUM_WAYS-1:0] first_free;

    assign all_below[0] = 1'b1;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_chain
        assign all_below[g+1] = all_below[g] & valid_i[g];
        assign first_free[g]  = all_below[g] & ~valid_i[g];
    end

    assign any_free_o = ~all_below[NUM_WAYS];

    // One-hot to binary encode of the first free way.
    always_comb begin
        free_idx_o = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (first_free[i]) begin
                free_idx_o = free_idx_o | WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/wa_rr_bank.sv
module wa_rr_bank #(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned SET_W    = 4,
    parameter int unsigned WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set_i,
    output logic [WAY_W-1:0] rd_ptr_o,
    input  logic             adv_i,
    input  logic [SET_W-1:0] adv_set_i
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

    typedef struct packed {
        logic [NUM_SETS-1:0][WAY_W-1:0] ptr;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (adv_i && (adv_set_i == SET_W'(s))) begin
                if (state_q.ptr[s] == LAST_WAY) begin
                    state_d.ptr[s] = '0;
                end else begin
                    state_d.ptr[s] = state_q.ptr[s] + WAY_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_ptr_o = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (rd_set_i == SET_W'(s)) begin
                rd_ptr_o = state_q.ptr[s];
            end
        end
    end

endmodule

// File: rtl/way_alloc_rr.sv
module way_alloc_rr #(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned NUM_WAYS = 4,
    localparam int unsigned SET_W   = wa_pkg::idx_width(NUM_SETS),
    localparam int unsigned WAY_W   = wa_pkg::idx_width(NUM_WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_W-1:0]    set_idx_i,
    input  logic [NUM_WAYS-1:0] way_valid_i,
    input  logic                commit_i,
    output logic [WAY_W-1:0]    way_sel_o,
    output logic                evict_o
);

    import wa_pkg::*;

    logic             any_free;
    logic [WAY_W-1:0] free_idx;
    logic [WAY_W-1:0] victim_idx;
    alloc_kind_e      kind;

    wa_free_finder #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_free (
        .valid_i    (way_valid_i),
        .any_free_o (any_free),
        .free_idx_o (free_idx)
    );

    wa_rr_bank #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS),
        .SET_W    (SET_W),
        .WAY_W    (WAY_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set_i  (set_idx_i),
        .rd_ptr_o  (victim_idx),
        .adv_i     (commit_i && (kind == ALLOC_EVICT)),
        .adv_set_i (set_idx_i)
    );

    always_comb begin
        kind      = any_free ? ALLOC_FILL : ALLOC_EVICT;
        way_sel_o = any_free ? free_idx : victim_idx;
        evict_o   = (kind == ALLOC_EVICT);
    end

endmodule

// File: rtl/wa_alloc_checker.sv
module wa_alloc_checker #(
    parameter int unsigned NUM_SETS = 16,
    parameter int unsigned NUM_WAYS = 4,
    parameter int unsigned SET_W    = 4,
    parameter int unsigned WAY_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [SET_W-1:0]    set_idx_i,
    input logic [NUM_WAYS-1:0] way_valid_i,
    input logic                commit_i,
    input logic [WAY_W-1:0]    way_sel_o,
    input logic                evict_o
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

    logic                full_now;
    logic [NUM_WAYS-1:0] below_mask;
    logic                seen_q;
    logic                prev_adv_q;
    logic                prev_commit_q;
    logic                prev_full_q;
    logic [SET_W-1:0]    prev_set_q;
    logic [WAY_W-1:0]    prev_sel_q;
    logic [WAY_W-1:0]    exp_next;

    always_comb begin
        full_now   = &way_valid_i;
        below_mask = (NUM_WAYS'(1) << way_sel_o) - NUM_WAYS'(1);
        exp_next   = (prev_sel_q == LAST_WAY) ? '0 : prev_sel_q + WAY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q        <= 1'b0;
            prev_adv_q    <= 1'b0;
            prev_commit_q <= 1'b0;
            prev_full_q   <= 1'b0;
            prev_set_q    <= '0;
            prev_sel_q    <= '0;
        end else begin
            seen_q        <= 1'b1;
            prev_adv_q    <= commit_i & evict_o;
            prev_commit_q <= commit_i;
            prev_full_q   <= full_now;
            prev_set_q    <= set_idx_i;
            prev_sel_q    <= way_sel_o;
        end
    end

    // R1: a free way is chosen, it is invalid and every way under it is valid
    p_lowest_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !full_now |-> (!evict_o && !way_valid_i[way_sel_o]
                       && ((way_valid_i & below_mask) == below_mask)));

    // R2: a full set always reports a displacement
    p_full_evicts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full_now |-> evict_o);

    // R3: committed displacement moves the same set's pointer on by one
    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && prev_adv_q && full_now && set_idx_i == prev_set_q)
            |-> way_sel_o == exp_next);

    // R6: without commit a full set keeps its victim
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !prev_commit_q && prev_full_q && full_now
         && set_idx_i == prev_set_q) |-> way_sel_o == prev_sel_q);

    // R8: first cycle out of reset every victim pointer reads 0
    p_reset_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_q && full_now) |-> way_sel_o == '0);

endmodule

bind way_alloc_rr wa_alloc_checker #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .SET_W    (SET_W),
    .WAY_W    (WAY_W)
) u_alloc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_idx_i   (set_idx_i),
    .way_valid_i (way_valid_i),
    .commit_i    (commit_i),
    .way_sel_o   (way_sel_o),
    .evict_o     (evict_o)
);

// File: tb/tb_way_alloc_rr.sv
`timescale 1ns/1ps
module tb_way_alloc_rr;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // main instance: 16 sets x 4 ways
    logic [3:0] set_m = '0;
    logic [3:0] vld_m = '0;
    logic       com_m = 1'b0;
    logic [1:0] sel_m;
    logic       ev_m;
    // direct mapped: 8 sets x 1 way
    logic [2:0] set_d = '0;
    logic [0:0] vld_d = '0;
    logic       com_d = 1'b0;
    logic [0:0] sel_d;
    logic       ev_d;
    // fully associative: 1 set x 8 ways
    logic [0:0] set_f = '0;
    logic [7:0] vld_f = '0;
    logic       com_f = 1'b0;
    logic [2:0] sel_f;
    logic       ev_f;

    way_alloc_rr #(.NUM_SETS(16), .NUM_WAYS(4)) dut (
        .clk(clk), .rst_n(rst_n), .set_idx_i(set_m), .way_valid_i(vld_m),
        .commit_i(com_m), .way_sel_o(sel_m), .evict_o(ev_m));

    way_alloc_rr #(.NUM_SETS(8), .NUM_WAYS(1)) dut_dm (
        .clk(clk), .rst_n(rst_n), .set_idx_i(set_d), .way_valid_i(vld_d),
        .commit_i(com_d), .way_sel_o(sel_d), .evict_o(ev_d));

    way_alloc_rr #(.NUM_SETS(1), .NUM_WAYS(8)) dut_fa (
        .clk(clk), .rst_n(rst_n), .set_idx_i(set_f), .way_valid_i(vld_f),
        .commit_i(com_f), .way_sel_o(sel_f), .evict_o(ev_f));

    typedef struct {
        int    id;
        int    exp_sel;
        bit    exp_ev;
        string req;
    } item_t;

    item_t q[$];
    int vectors = 0;
    int misses  = 0;
    int ptr_m[16];
    int ptr_f;
    bit done = 1'b0;

    task automatic clear_model();
        foreach (ptr_m[i]) ptr_m[i] = 0;
        ptr_f = 0;
    endtask

    // Driver: present one vector to one instance and queue the expectation.
    task automatic apply(input int id, input int set, input logic [7:0] vld,
                         input bit commit, input string req);
        int    ways;
        int    sel;
        bit    ev;
        item_t it;
        @(negedge clk);
        com_m = 1'b0; com_d = 1'b0; com_f = 1'b0;
        case (id)
            0: begin set_m = 4'(set); vld_m = vld[3:0]; com_m = commit; ways = 4; end
            1: begin set_d = 3'(set); vld_d = vld[0:0]; com_d = commit; ways = 1; end
            default: begin vld_f = vld; com_f = commit; ways = 8; end
        endcase
        sel = -1;
        for (int w = ways - 1; w >= 0; w--) begin
            if (!vld[w]) sel = w;
        end
        ev = (sel < 0);
        if (ev) sel = (id == 0) ? ptr_m[set] : (id == 2) ? ptr_f : 0;
        it.id = id; it.exp_sel = sel; it.exp_ev = ev; it.req = req;
        q.push_back(it);
        vectors++;
        if (commit && ev) begin
            if (id == 0) ptr_m[set] = (ptr_m[set] + 1) % 4;
            if (id == 2) ptr_f = (ptr_f + 1) % 8;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        com_m = 1'b0; com_d = 1'b0; com_f = 1'b0;
    endtask

    // Monitor: compare queued expectations once outputs have settled.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                int    act_sel;
                bit    act_ev;
                it = q.pop_front();
                case (it.id)
                    0: begin act_sel = int'(sel_m); act_ev = ev_m; end
                    1: begin act_sel = int'(sel_d); act_ev = ev_d; end
                    default: begin act_sel = int'(sel_f); act_ev = ev_f; end
                endcase
                if (act_sel != it.exp_sel || act_ev != it.exp_ev) begin
                    misses++;
                    $display("FAIL %s inst%0d: way=%0d evict=%0d, expected way=%0d evict=%0d",
                             it.req, it.id, act_sel, act_ev, it.exp_sel, it.exp_ev);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: pointers start at 0 in several sets
        apply(0, 0, 8'h0F, 0, "R8");
        apply(0, 9, 8'h0F, 0, "R8");
        apply(0, 15, 8'h0F, 0, "R8");

        // R1: lowest free way, including holes above valid ways
        apply(0, 2, 8'h00, 0, "R1");
        apply(0, 2, 8'h01, 0, "R1");
        apply(0, 2, 8'h0B, 0, "R1");
        apply(0, 2, 8'h07, 0, "R1");
        apply(0, 2, 8'h0E, 0, "R1");
        apply(0, 2, 8'h05, 0, "R1");

        // R5: committed fills leave the pointer alone
        apply(0, 5, 8'h07, 1, "R5");
        apply(0, 5, 8'h0D, 1, "R5");
        apply(0, 5, 8'h0F, 0, "R5");

        // R2/R3/R4: committed displacements walk through the wrap
        for (int k = 0; k < 5; k++) apply(0, 5, 8'h0F, 1, "R3");
        apply(0, 5, 8'h0F, 0, "R4");

        // R6: long uncommitted full lookup holds the victim
        for (int k = 0; k < 4; k++) apply(0, 5, 8'h0F, 0, "R6");

        // R7: interleaved sets keep separate pointers
        apply(0, 6, 8'h0F, 0, "R7");
        apply(0, 5, 8'h0F, 1, "R7");
        apply(0, 6, 8'h0F, 1, "R7");
        apply(0, 5, 8'h0F, 1, "R7");
        apply(0, 6, 8'h0F, 0, "R7");
        apply(0, 5, 8'h0F, 0, "R7");
        apply(0, 7, 8'h0F, 0, "R7");

        // R2 with commit low after traffic
        apply(0, 6, 8'h0F, 0, "R2");

        // R9: direct mapped instance
        apply(1, 3, 8'h00, 0, "R9");
        apply(1, 3, 8'h01, 1, "R9");
        apply(1, 3, 8'h01, 1, "R9");
        apply(1, 4, 8'h01, 0, "R9");
        apply(1, 4, 8'h00, 1, "R9");

        // R10: single set rotates through all eight ways and wraps
        apply(2, 0, 8'h7F, 1, "R10");
        apply(2, 0, 8'hF7, 0, "R10");
        for (int k = 0; k < 10; k++) apply(2, 0, 8'hFF, 1, "R10");

        // R8: reset mid-run returns pointers to 0
        idle();
        rst_n = 1'b0;
        clear_model();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        apply(0, 5, 8'h0F, 0, "R8");
        apply(0, 6, 8'h0F, 0, "R8");
        apply(2, 0, 8'hFF, 0, "R8");

        idle();
        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule